// File: doc/BRIEF.md
# Interrupt Vector and Mask Controller

This block sits beside a small 8-bit CPU that fetches from a 16-bit instruction address space. It collects five maskable interrupt sources and one non-maskable request, picks one winner by fixed priority, and hands the CPU a request line together with a latched 16-bit vector address. The high byte of that address comes from a programmable base register, so software can place its vector table in any 256-byte page. The low byte is a fixed offset for each source. The request and the vector stay put until the CPU answers with an acknowledge pulse.

Software configures the controller through a small register bus with a 2-bit select: a base byte, a five-bit enable mask, and a control word that holds the global enable and the direction of a bidirectional request pin. When that pin is an input, it acts as maskable source 3 and enable bit 3 gates it. When the pin is an output, enable bit 3 sets the level driven on it and source 3 never requests. Taking any maskable interrupt clears the global enable, so the handler runs with maskable sources held off until software sets the enable again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `cpu_irq` is 0, the base, enable-mask and control registers read 00h, and `pin_oe` and `pin_out` are 0.
- R2: A write with `reg_wr`=1 stores `reg_wdata` at the next rising edge into the register picked by `reg_sel`: 0 selects the base (8 bits), 1 selects the enable mask (bits 4:0, bits 7:5 read 0), 2 selects control (bit 0 global enable, bit 1 pin direction with 1 meaning output). `reg_rdata` shows the selected register combinationally, and select 3 reads 00h.
- R3: The latched vector is {base, offset}. The offset is 1Ch for the non-maskable request and 1Ch - 4*(k+1) for maskable source k, so 18h, 14h, 10h, 0Ch and 08h for sources 0 to 4. The base used is the value held at the edge where the interrupt is taken.
- R4: The non-maskable request ignores the mask and the global enable. Each rising edge of `nmi_in` produces exactly one request, however long `nmi_in` stays high.
- R5: Maskable source k is taken only when its request is high, enable bit k is 1 and the global enable is 1.
- R6: When several requests compete, the non-maskable one wins, then source 0, then 1, 2, 3, and source 4 comes last.
- R7: Taking a maskable interrupt clears the global enable at the same edge, and this clear overrides a software write of the enable in that cycle. Taking the non-maskable request leaves the global enable unchanged.
- R8: Once `cpu_irq` is high, it and `vec_addr` hold unchanged until `irq_ack` is sampled high. `cpu_irq` then falls at that edge, and the next interrupt can be taken no earlier than the following edge.
- R9: With the pin direction set to input, `pin_oe` is 0 and `pin_in` is the request of source 3, gated by enable bit 3. External sources 0, 1, 2 and 4 arrive on `ext_req[0]`, `[1]`, `[2]` and `[3]`.
- R10: With the pin direction set to output, `pin_oe` is 1, `pin_out` equals enable bit 3, and `pin_in` causes no request.
- R11: A maskable interrupt is taken at the first rising edge at which it is eligible and no request is outstanding. The non-maskable request is taken at the second rising edge after `nmi_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 base, 1 enable mask, 2 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_req | input | 4 | Level requests of maskable sources 0, 1, 2, 4 |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| pin_in | input | 1 | Value sensed on the bidirectional request pin |
| pin_out | output | 1 | Level driven on the bidirectional request pin |
| pin_oe | output | 1 | Output enable of the bidirectional request pin |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| irq_ack | input | 1 | Acknowledge pulse from the CPU |
| vec_addr | output | 16 | Latched vector address |

## Verification
Two pairs of events can land on the same edge. In the first, a maskable interrupt is taken while software writes the global enable. The bench raises source 1 and writes the enable as 1 in the same cycle, then reads the control register and expects the automatic clear to have won. In the second, a non-maskable edge and a pending maskable request arrive while an earlier vector is still held. The bench checks that the held vector survives a rewrite of the base, that the non-maskable vector (built from the new base) comes out first after the acknowledge with the enable still set, and that the maskable one follows after the next acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // register select codes on the CPU register bus
   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_MASK = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } irq_sel_e;

   // bit positions inside the control register
   localparam int CTRL_GIE_BIT = 0;
   localparam int CTRL_DIR_BIT = 1;

   typedef struct packed {
      logic dir_out;   // 1: request pin is an output
      logic gie;       // global enable of maskable sources
   } irq_ctrl_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         sel,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               take_maskable,
   output logic [DATA_W-1:0]  rd_data,
   output logic [DATA_W-1:0]  base_q,
   output logic [NUM_SRC-1:0] mask_q,
   output logic               gie_q,
   output logic               dir_q
);
   irq_sel_e  sel_e;
   irq_ctrl_t ctrl_q;

   assign sel_e = irq_sel_e'(sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_en && sel_e == SEL_BASE) base_q <= wr_data;
         if (wr_en && sel_e == SEL_MASK) mask_q <= wr_data[NUM_SRC-1:0];
         if (wr_en && sel_e == SEL_CTRL) begin
            ctrl_q.dir_out <= wr_data[CTRL_DIR_BIT];
            ctrl_q.gie     <= wr_data[CTRL_GIE_BIT];
         end
         // automatic clear wins over a simultaneous software write
         if (take_maskable) ctrl_q.gie <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (sel_e)
         SEL_BASE: rd_data = base_q;
         SEL_MASK: rd_data[NUM_SRC-1:0] = mask_q;
         SEL_CTRL: begin
            rd_data[CTRL_GIE_BIT] = ctrl_q.gie;
            rd_data[CTRL_DIR_BIT] = ctrl_q.dir_out;
         end
         default:  rd_data = '0;
      endcase
   end

   assign gie_q = ctrl_q.gie;
   assign dir_q = ctrl_q.dir_out;
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map #(
   parameter int NUM_SRC = 5,
   parameter int PIN_IDX = 3
) (
   input  logic [NUM_SRC-2:0] ext_req,
   input  logic               pin_in,
   input  logic               dir_out,
   input  logic [NUM_SRC-1:0] mask_q,
   input  logic               gie,
   output logic [NUM_SRC-1:0] eligible,
   output logic               pin_out,
   output logic               pin_oe
);
   logic [NUM_SRC-1:0] raw;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
      if (i < PIN_IDX) begin : g_lo
         assign raw[i] = ext_req[i];
      end else if (i == PIN_IDX) begin : g_pin
         // the pin only requests while it is an input
         assign raw[i] = pin_in & ~dir_out;
      end else begin : g_hi
         assign raw[i] = ext_req[i-1];
      end
   end

   assign eligible = raw & mask_q & {NUM_SRC{gie}};
   assign pin_oe   = dir_out;
   assign pin_out  = dir_out & mask_q[PIN_IDX];
endmodule

// File: rtl/irq_priority.sv
module irq_priority #(
   parameter int                NUM_SRC    = 5,
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] NMI_OFS    = 8'h1C,
   parameter int                VEC_STRIDE = 4
) (
   input  logic               nmi_pend,
   input  logic [NUM_SRC-1:0] eligible,
   output logic               any_req,
   output logic [NUM_SRC-1:0] grant,
   output logic [DATA_W-1:0]  vec_lo
);
   logic [NUM_SRC:0] blocked;

   assign blocked[0] = nmi_pend;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      assign grant[i]     = eligible[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | eligible[i];
   end

   assign any_req = blocked[NUM_SRC];

   always_comb begin
      vec_lo = NMI_OFS;
      if (!nmi_pend) begin
         for (int k = 0; k < NUM_SRC; k++) begin
            if (grant[k]) vec_lo = NMI_OFS - DATA_W'(VEC_STRIDE * (k + 1));
         end
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int          DATA_W     = 8,
   parameter int          NUM_SRC    = 5,
   parameter int          PIN_IDX    = 3,
   parameter logic [7:0]  NMI_OFS    = 8'h1C,
   parameter int          VEC_STRIDE = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [1:0]          reg_sel,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_SRC-2:0]  ext_req,
   input  logic                nmi_in,
   input  logic                pin_in,
   output logic                pin_out,
   output logic                pin_oe,
   output logic                cpu_irq,
   input  logic                irq_ack,
   output logic [2*DATA_W-1:0] vec_addr
);
   localparam int ADDR_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] NMI_LO = DATA_W'(NMI_OFS);

   initial begin
      pin_idx_range_chk: assert (PIN_IDX >= 0 && PIN_IDX < NUM_SRC)
         else $error("PIN_IDX outside the source range");
      src_count_chk: assert (NUM_SRC >= 2 && NUM_SRC <= DATA_W)
         else $error("NUM_SRC must lie between 2 and DATA_W");
      offset_fit_chk: assert (int'(NMI_OFS) >= VEC_STRIDE * NUM_SRC)
         else $error("vector offsets do not fit below the NMI offset");
      stride_chk: assert (VEC_STRIDE > 0)
         else $error("VEC_STRIDE must be positive");
   end

   logic [DATA_W-1:0]  base_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               gie_q;
   logic               dir_q;
   logic [NUM_SRC-1:0] eligible;
   logic [NUM_SRC-1:0] grant;
   logic               any_req;
   logic [DATA_W-1:0]  vec_lo;
   logic               nmi_prev;
   logic               nmi_pend;
   logic               busy_q;
   logic [ADDR_W-1:0]  vec_q;
   logic               take;
   logic               take_maskable;

   assign take          = ~busy_q & any_req;
   assign take_maskable = take & ~nmi_pend;

   irq_cfg_regs #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (reg_wr),
      .sel           (reg_sel),
      .wr_data       (reg_wdata),
      .take_maskable (take_maskable),
      .rd_data       (reg_rdata),
      .base_q        (base_q),
      .mask_q        (mask_q),
      .gie_q         (gie_q),
      .dir_q         (dir_q)
   );

   irq_src_map #(
      .NUM_SRC (NUM_SRC),
      .PIN_IDX (PIN_IDX)
   ) u_map (
      .ext_req  (ext_req),
      .pin_in   (pin_in),
      .dir_out  (dir_q),
      .mask_q   (mask_q),
      .gie      (gie_q),
      .eligible (eligible),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

   irq_priority #(
      .NUM_SRC    (NUM_SRC),
      .DATA_W     (DATA_W),
      .NMI_OFS    (NMI_LO),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_prio (
      .nmi_pend (nmi_pend),
      .eligible (eligible),
      .any_req  (any_req),
      .grant    (grant),
      .vec_lo   (vec_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev <= 1'b0;
         nmi_pend <= 1'b0;
         busy_q   <= 1'b0;
         vec_q    <= '0;
      end else begin
         nmi_prev <= nmi_in;
         if (take && nmi_pend) nmi_pend <= 1'b0;
         // a fresh edge in the same cycle is kept
         if (nmi_in && !nmi_prev) nmi_pend <= 1'b1;
         if (take) begin
            busy_q <= 1'b1;
            vec_q  <= {base_q, vec_lo};
         end else if (busy_q && irq_ack) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign cpu_irq  = busy_q;
   assign vec_addr = vec_q;
endmodule

module irq_vector_ctrl_chk #(
   parameter int         DATA_W  = 8,
   parameter logic [7:0] NMI_OFS = 8'h1C
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_irq,
   input logic                irq_ack,
   input logic [2*DATA_W-1:0] vec_addr,
   input logic [DATA_W-1:0]   base,
   input logic                gie
);
   localparam logic [DATA_W-1:0] NMI_LO = DATA_W'(NMI_OFS);

   // R8
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && !irq_ack) |=> (cpu_irq && $stable(vec_addr)));

   // R8
   release_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && irq_ack) |=> !cpu_irq);

   // R3
   vector_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq) |-> (vec_addr[2*DATA_W-1:DATA_W] == $past(base)));

   // R5
   maskable_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_irq) && vec_addr[DATA_W-1:0] != NMI_LO) |-> $past(gie));

   // R7
   maskable_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_irq) && vec_addr[DATA_W-1:0] != NMI_LO) |-> !gie);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .DATA_W  (DATA_W),
   .NMI_OFS (NMI_OFS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_irq  (cpu_irq),
   .irq_ack  (irq_ack),
   .vec_addr (vec_addr),
   .base     (base_q),
   .gie      (gie_q)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/100ps
module irq_vector_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [3:0]  ext_req = 4'h0;
   logic        nmi_in = 1'b0;
   logic        pin_in = 1'b0;
   logic        pin_out;
   logic        pin_oe;
   logic        cpu_irq;
   logic        irq_ack = 1'b0;
   logic [15:0] vec_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ext_req   (ext_req),
      .nmi_in    (nmi_in),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .cpu_irq   (cpu_irq),
      .irq_ack   (irq_ack),
      .vec_addr  (vec_addr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      reg_sel = s;
      #1;
      d = reg_rdata;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      step();
      irq_ack = 1'b0;
   endtask

   task automatic expect_vec(input string req, input logic [15:0] v);
      check(cpu_irq === 1'b1, req, "cpu_irq raised", 32'(cpu_irq), 1);
      check(vec_addr === v, req, "vector", 32'(vec_addr), 32'(v));
   endtask

   task automatic expect_quiet(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         step();
         check(cpu_irq === 1'b0, req, "no request", 32'(cpu_irq), 0);
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check(cpu_irq === 1'b0, "R1", "cpu_irq", 32'(cpu_irq), 0);
      rd(2'd0, d); check(d === 8'h00, "R1", "base", 32'(d), 0);
      rd(2'd1, d); check(d === 8'h00, "R1", "mask", 32'(d), 0);
      rd(2'd2, d); check(d === 8'h00, "R1", "ctrl", 32'(d), 0);
      check(pin_oe === 1'b0 && pin_out === 1'b0, "R1", "pin",
            {30'd0, pin_oe, pin_out}, 0);
      step();
   endtask

   task automatic t_nmi_first();
      // R4 R11: base still 00h, nothing enabled
      nmi_in = 1'b1;
      step();
      check(cpu_irq === 1'b0, "R11", "nmi after one edge", 32'(cpu_irq), 0);
      step();
      expect_vec("R4", 16'h001C);
      ack();
      check(cpu_irq === 1'b0, "R8", "drop after ack", 32'(cpu_irq), 0);
      expect_quiet("R4", 4);
      nmi_in = 1'b0;
      step();
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(2'd0, 8'hA5); rd(2'd0, d); check(d === 8'hA5, "R2", "base", 32'(d), 32'hA5);
      wr(2'd1, 8'hFF); rd(2'd1, d); check(d === 8'h1F, "R2", "mask", 32'(d), 32'h1F);
      wr(2'd2, 8'hFF); rd(2'd2, d); check(d === 8'h03, "R2", "ctrl", 32'(d), 32'h03);
      rd(2'd3, d); check(d === 8'h00, "R2", "unused select", 32'(d), 0);
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      step();
   endtask

   task automatic t_gate();
      logic [7:0] d;
      wr(2'd0, 8'h12);
      ext_req[1] = 1'b1;
      wr(2'd2, 8'h01);                 // GIE on, mask off
      expect_quiet("R5", 3);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h02);                 // mask on, GIE off
      expect_quiet("R5", 3);
      wr(2'd2, 8'h01);
      check(cpu_irq === 1'b0, "R11", "take one edge after enable", 32'(cpu_irq), 0);
      step();
      expect_vec("R3", 16'h1214);
      rd(2'd2, d); check(d[0] === 1'b0, "R7", "gie cleared", 32'(d[0]), 0);
      ack();
      ext_req[1] = 1'b0;
      step();
   endtask

   task automatic t_priority();
      wr(2'd0, 8'h40);
      wr(2'd1, 8'h1F);
      ext_req = 4'b1101;               // sources 0, 2, 4
      wr(2'd2, 8'h01);
      step();
      expect_vec("R6", 16'h4018);
      ack(); ext_req[0] = 1'b0;
      wr(2'd2, 8'h01); step();
      expect_vec("R6", 16'h4010);
      ack(); ext_req[2] = 1'b0;
      wr(2'd2, 8'h01); step();
      expect_vec("R6", 16'h4008);
      ack(); ext_req = 4'h0;
      step();
   endtask

   task automatic t_nmi_vs_mask();
      logic [7:0] d;
      wr(2'd1, 8'h01);
      ext_req[0] = 1'b1;
      wr(2'd2, 8'h01); step();
      expect_vec("R3", 16'h4018);
      nmi_in = 1'b1;
      wr(2'd2, 8'h01);                 // re-enable while held
      wr(2'd0, 8'h77);
      step(2);
      expect_vec("R8", 16'h4018);      // held despite new base and NMI
      ack();
      check(cpu_irq === 1'b0, "R8", "gap after ack", 32'(cpu_irq), 0);
      step();
      expect_vec("R6", 16'h771C);
      rd(2'd2, d); check(d[0] === 1'b1, "R7", "nmi keeps gie", 32'(d[0]), 1);
      ack(); step();
      expect_vec("R6", 16'h7718);
      rd(2'd2, d); check(d[0] === 1'b0, "R7", "gie cleared", 32'(d[0]), 0);
      ack();
      ext_req = 4'h0; nmi_in = 1'b0;
      step();
   endtask

   task automatic t_same_cycle();
      logic [7:0] d;
      wr(2'd1, 8'h02);
      wr(2'd2, 8'h01);
      ext_req[1] = 1'b1;
      wr(2'd2, 8'h01);                 // write lands on the take edge
      expect_vec("R7", 16'h7714);
      rd(2'd2, d); check(d[0] === 1'b0, "R7", "clear beats write", 32'(d[0]), 0);
      ack();
      ext_req[1] = 1'b0;
      step();
   endtask

   task automatic t_pin_in();
      wr(2'd2, 8'h01);
      wr(2'd1, 8'h00);
      pin_in = 1'b1;
      expect_quiet("R9", 3);
      check(pin_oe === 1'b0, "R9", "pin_oe", 32'(pin_oe), 0);
      wr(2'd1, 8'h08);
      step();
      expect_vec("R9", 16'h770C);
      ack();
      pin_in = 1'b0;
      step();
   endtask

   task automatic t_pin_out();
      wr(2'd2, 8'h03);
      wr(2'd1, 8'h08);
      check(pin_oe === 1'b1, "R10", "pin_oe", 32'(pin_oe), 1);
      check(pin_out === 1'b1, "R10", "pin high", 32'(pin_out), 1);
      pin_in = 1'b1;
      expect_quiet("R10", 3);
      wr(2'd1, 8'h00);
      check(pin_out === 1'b0, "R10", "pin low", 32'(pin_out), 0);
      wr(2'd2, 8'h00);
      check(pin_oe === 1'b0, "R10", "pin released", 32'(pin_oe), 0);
      pin_in = 1'b0;
      step();
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_nmi_first();
      t_regs();
      t_gate();
      t_priority();
      t_nmi_vs_mask();
      t_same_cycle();
      t_pin_in();
      t_pin_out();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R8 watchdog: actual done=0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule